// File: doc/BRIEF.md
# Dirty Rectangle Redraw Queue

This block collects screen regions that drawing operations have touched and hands them, in order, to a downstream line-copy engine when the display refresh asks for them. Each pushed region is a rectangle given by its left edge, top edge, width and height in pixels. The queue is circular and has no fullness check, so a burst of pushes longer than its depth overwrites the oldest regions.

A refresh pulse starts a drain. If a full-screen invalidate was signalled since the last refresh, the drain drops every pending region at once, because the whole screen is going to be redrawn anyway. Otherwise the regions leave one by one in arrival order. Each one is clipped against the screen size present when it leaves, then turned into a start byte address, a row count, a row byte width and a row pitch. A one-cycle completion pulse marks the moment the queue is empty and the last region has been accepted.

Top module: `redraw_queue`

## Requirements
- R1: After reset the queue is empty: `rect_valid`, `busy` and `done` are low, and a refresh with no pushes emits no region and raises `done`.
- R2: Regions leave in the order they were pushed, and a drain continues until every pushed region has left.
- R3: Pushes wrap at the queue depth (512 by default) with no fullness check: after depth+1 pushes into an empty queue, a refresh emits exactly one region, the last one pushed.
- R4: A refresh while the invalidate flag is set drops all pending regions, emits none, raises `done` in the cycle after the refresh, and clears the flag so the next refresh replays new pushes.
- R5: When left edge plus width exceeds the screen width, the left edge becomes the smaller of the left edge and the screen width, and the width becomes the screen width minus that edge (zero when the edge is at or past the screen).
- R6: When top edge plus height exceeds the screen height, the top edge and height are clipped the same way against the screen height; `rect_rows` carries the clipped height.
- R7: `rect_addr` is bpp*x + bpp*screen_width*y of the clipped region, `rect_pitch` is bpp*screen_width and `rect_bytes` is bpp*clipped_width, with bpp the bytes per pixel; a region inside the screen passes unchanged.
- R8: A refresh pulse while a drain is in progress has no effect: the drain emits each region once and ends with a single `done`.
- R9: `done` is a one-cycle pulse raised in the cycle after the last region is accepted, with `busy` and `rect_valid` low while it is high.
- R10: While `rect_valid` is high and `rect_ready` is low, `rect_valid` and every region output stay unchanged into the next cycle.
- R11: Screen size and bytes per pixel are sampled when a region leaves the queue, not when it is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Store one region this cycle |
| push_x | input | 12 | Region left edge in pixels |
| push_y | input | 12 | Region top edge in pixels |
| push_w | input | 12 | Region width in pixels |
| push_h | input | 12 | Region height in pixels |
| refresh | input | 1 | Pulse: start a drain |
| invalidate | input | 1 | Pulse: whole screen will be redrawn, next drain drops pending regions |
| scr_w | input | 12 | Current screen width in pixels |
| scr_h | input | 12 | Current screen height in pixels |
| bpp | input | 3 | Bytes per pixel |
| rect_valid | output | 1 | Region outputs hold a copy request |
| rect_ready | input | 1 | Downstream accepts the request |
| rect_addr | output | 32 | Start byte address of the first row |
| rect_rows | output | 12 | Number of rows to copy |
| rect_bytes | output | 15 | Bytes to copy in each row |
| rect_pitch | output | 15 | Byte distance between rows |
| busy | output | 1 | Drain in progress |
| done | output | 1 | One-cycle pulse: drain finished |

## Verification
On every cycle the assertions check that a stalled request holds still, that a region never asks for more bytes per row than the pitch, that requests appear only during a drain, and that the completion pulse is a single cycle with the block idle. Order across the queue, the wrap after an overlong burst, dropping on an invalidated refresh, the exact clipped coordinates and byte arithmetic, and sampling of the screen size at the time a region leaves can only be shown by the bench's scenarios, which compare every emitted request against a model of the queue.

// File: rtl/rdq_pkg.sv
// Shared types for the redraw queue.
// Assumes coordinates fit in COORD_W bits and are unsigned.
package rdq_pkg;
    parameter int COORD_W = 12;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t w;
        coord_t h;
    } rect_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } rdq_state_e;
endpackage

// File: rtl/rdq_store.sv
// Circular region store: writes at the tail, reads at the head.
// Assumes DEPTH is a power of two so index wrap is the natural counter
// overflow. No fullness check: overflow overwrites old entries.
module rdq_store
    import rdq_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  rect_t wr_rect,
    input  logic  pop,
    input  logic  drop,
    output rect_t head_rect,
    output logic  empty
);
    localparam int IW = $clog2(DEPTH);

    rect_t          mem [DEPTH];
    logic [IW-1:0]  head_q;
    logic [IW-1:0]  tail_q;

    // Entry storage, written at the tail index.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[tail_q] <= wr_rect;
        end
    end

    // Tail index: advances on every push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else if (wr_en) begin
            tail_q <= tail_q + 1'b1;
        end
    end

    // Head index: jumps to the tail on drop, steps on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (drop) begin
            head_q <= tail_q;
        end else if (pop) begin
            head_q <= head_q + 1'b1;
        end
    end

    assign head_rect = mem[head_q];
    assign empty     = (head_q == tail_q);
endmodule

// File: rtl/rdq_clip.sv
// Clips a region against the screen and derives its copy request.
// Purely combinational; the same clip rule is generated for both axes.
module rdq_clip
    import rdq_pkg::*;
#(
    parameter int BPP_W  = 3,
    parameter int ADDR_W = 32
) (
    input  rect_t                      rect_in,
    input  coord_t                     scr_w,
    input  coord_t                     scr_h,
    input  logic [BPP_W-1:0]           bpp,
    output logic [ADDR_W-1:0]          addr,
    output coord_t                     rows,
    output logic [COORD_W+BPP_W-1:0]   bytes,
    output logic [COORD_W+BPP_W-1:0]   pitch
);
    localparam int PW = COORD_W + BPP_W;

    coord_t pos_in [2];
    coord_t len_in [2];
    coord_t lim    [2];
    coord_t pos_c  [2];
    coord_t len_c  [2];

    assign pos_in[0] = rect_in.x;
    assign len_in[0] = rect_in.w;
    assign lim[0]    = scr_w;
    assign pos_in[1] = rect_in.y;
    assign len_in[1] = rect_in.h;
    assign lim[1]    = scr_h;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [COORD_W:0] span_end;
        coord_t           pos_lim;

        assign span_end = {1'b0, pos_in[a]} + {1'b0, len_in[a]};
        assign pos_lim  = (pos_in[a] > lim[a]) ? lim[a] : pos_in[a];

        // Axis clip: pull the edge inside and shrink the length.
        always_comb begin
            if (span_end > {1'b0, lim[a]}) begin
                pos_c[a] = pos_lim;
                len_c[a] = lim[a] - pos_lim;
            end else begin
                pos_c[a] = pos_in[a];
                len_c[a] = len_in[a];
            end
        end
    end

    logic [ADDR_W-1:0] col_off;
    logic [ADDR_W-1:0] row_off;

    // Byte arithmetic for the copy request.
    always_comb begin
        col_off = ADDR_W'(bpp) * ADDR_W'(pos_c[0]);
        row_off = ADDR_W'(bpp) * ADDR_W'(scr_w) * ADDR_W'(pos_c[1]);
        addr    = col_off + row_off;
        rows    = len_c[1];
        bytes   = PW'(bpp) * PW'(len_c[0]);
        pitch   = PW'(bpp) * PW'(scr_w);
    end
endmodule

// File: rtl/rdq_ctrl.sv
// Drain controller: starts a drain on refresh, drops the queue when the
// invalidate flag is set, and owns the output request registers.
// Assumes the clip results are valid in the same cycle as the head entry.
module rdq_ctrl
    import rdq_pkg::*;
#(
    parameter int BPP_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       refresh,
    input  logic                       invalidate,
    input  logic                       empty,
    input  logic [ADDR_W-1:0]          c_addr,
    input  coord_t                     c_rows,
    input  logic [COORD_W+BPP_W-1:0]   c_bytes,
    input  logic [COORD_W+BPP_W-1:0]   c_pitch,
    input  logic                       rect_ready,
    output logic                       pop,
    output logic                       drop,
    output logic                       rect_valid,
    output logic [ADDR_W-1:0]          rect_addr,
    output coord_t                     rect_rows,
    output logic [COORD_W+BPP_W-1:0]   rect_bytes,
    output logic [COORD_W+BPP_W-1:0]   rect_pitch,
    output logic                       busy,
    output logic                       done
);
    rdq_state_e state_q;
    logic       inval_q;
    logic       can_load;
    logic       finish;

    // Decode pop, drop and end of drain for this cycle.
    always_comb begin
        can_load = !rect_valid || rect_ready;
        pop      = (state_q == ST_DRAIN) && can_load && !empty;
        finish   = (state_q == ST_DRAIN) && can_load && empty;
        drop     = (state_q == ST_IDLE) && refresh && inval_q;
    end

    // Sticky invalidate flag, consumed by the next idle refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_q <= 1'b0;
        end else if (invalidate) begin
            inval_q <= 1'b1;
        end else if (drop) begin
            inval_q <= 1'b0;
        end
    end

    // Drain state; refresh is ignored unless idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (state_q == ST_IDLE) begin
            if (refresh && !inval_q) begin
                state_q <= ST_DRAIN;
            end
        end else if (finish) begin
            state_q <= ST_IDLE;
        end
    end

    // Completion pulse after a drop or after the last accepted region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= drop || finish;
        end
    end

    // Request valid: set on each pop, cleared when the drain ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rect_valid <= 1'b0;
        end else if (pop) begin
            rect_valid <= 1'b1;
        end else if (finish) begin
            rect_valid <= 1'b0;
        end
    end

    // Request payload: loaded only on pop, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rect_addr  <= '0;
            rect_rows  <= '0;
            rect_bytes <= '0;
            rect_pitch <= '0;
        end else if (pop) begin
            rect_addr  <= c_addr;
            rect_rows  <= c_rows;
            rect_bytes <= c_bytes;
            rect_pitch <= c_pitch;
        end
    end

    assign busy = (state_q == ST_DRAIN);
endmodule

// File: rtl/redraw_queue.sv
// Top of the redraw queue: region store, clip unit and drain controller.
// Assumes screen size and bytes per pixel are stable during a drain
// only to the extent the caller wants; they are sampled per pop.
module redraw_queue
    import rdq_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int BPP_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [COORD_W-1:0]         push_x,
    input  logic [COORD_W-1:0]         push_y,
    input  logic [COORD_W-1:0]         push_w,
    input  logic [COORD_W-1:0]         push_h,
    input  logic                       refresh,
    input  logic                       invalidate,
    input  logic [COORD_W-1:0]         scr_w,
    input  logic [COORD_W-1:0]         scr_h,
    input  logic [BPP_W-1:0]           bpp,
    output logic                       rect_valid,
    input  logic                       rect_ready,
    output logic [ADDR_W-1:0]          rect_addr,
    output logic [COORD_W-1:0]         rect_rows,
    output logic [COORD_W+BPP_W-1:0]   rect_bytes,
    output logic [COORD_W+BPP_W-1:0]   rect_pitch,
    output logic                       busy,
    output logic                       done
);
    localparam int PW = COORD_W + BPP_W;

    rect_t             in_rect;
    rect_t             head_rect;
    logic              empty;
    logic              pop;
    logic              drop;
    logic [ADDR_W-1:0] c_addr;
    coord_t            c_rows;
    logic [PW-1:0]     c_bytes;
    logic [PW-1:0]     c_pitch;

    assign in_rect = '{x: push_x, y: push_y, w: push_w, h: push_h};

    rdq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push_valid),
        .wr_rect   (in_rect),
        .pop       (pop),
        .drop      (drop),
        .head_rect (head_rect),
        .empty     (empty)
    );

    rdq_clip #(.BPP_W(BPP_W), .ADDR_W(ADDR_W)) u_clip (
        .rect_in (head_rect),
        .scr_w   (scr_w),
        .scr_h   (scr_h),
        .bpp     (bpp),
        .addr    (c_addr),
        .rows    (c_rows),
        .bytes   (c_bytes),
        .pitch   (c_pitch)
    );

    rdq_ctrl #(.BPP_W(BPP_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .refresh    (refresh),
        .invalidate (invalidate),
        .empty      (empty),
        .c_addr     (c_addr),
        .c_rows     (c_rows),
        .c_bytes    (c_bytes),
        .c_pitch    (c_pitch),
        .rect_ready (rect_ready),
        .pop        (pop),
        .drop       (drop),
        .rect_valid (rect_valid),
        .rect_addr  (rect_addr),
        .rect_rows  (rect_rows),
        .rect_bytes (rect_bytes),
        .rect_pitch (rect_pitch),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/rdq_checker.sv
// Port-level protocol checks for the redraw queue, bound to the top.
module rdq_checker #(
    parameter int CW     = 12,
    parameter int PW     = 15,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              refresh,
    input logic              rect_valid,
    input logic              rect_ready,
    input logic [ADDR_W-1:0] rect_addr,
    input logic [CW-1:0]     rect_rows,
    input logic [PW-1:0]     rect_bytes,
    input logic [PW-1:0]     rect_pitch,
    input logic              busy,
    input logic              done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rect_valid && !busy && !done));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_addr)
            && $stable(rect_rows) && $stable(rect_bytes) && $stable(rect_pitch)));

    // R5
    row_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> (rect_bytes <= rect_pitch));

    // R8
    valid_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rect_valid));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !refresh) |=> !done);
endmodule

bind redraw_queue rdq_checker #(
    .CW     (rdq_pkg::COORD_W),
    .PW     (rdq_pkg::COORD_W + BPP_W),
    .ADDR_W (ADDR_W)
) u_rdq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh    (refresh),
    .rect_valid (rect_valid),
    .rect_ready (rect_ready),
    .rect_addr  (rect_addr),
    .rect_rows  (rect_rows),
    .rect_bytes (rect_bytes),
    .rect_pitch (rect_pitch),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_redraw_queue.sv
`timescale 1ns/1ps
module test_redraw_queue;
    localparam int DEPTH = 512;
    localparam int CW    = 12;
    localparam int BW    = 3;
    localparam int AW    = 32;
    localparam int PW    = CW + BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [CW-1:0] push_x = '0, push_y = '0, push_w = '0, push_h = '0;
    logic          refresh = 1'b0;
    logic          invalidate = 1'b0;
    logic [CW-1:0] scr_w = 12'd640, scr_h = 12'd480;
    logic [BW-1:0] bpp = 3'd4;
    logic          rect_valid;
    logic          rect_ready = 1'b0;
    logic [AW-1:0] rect_addr;
    logic [CW-1:0] rect_rows;
    logic [PW-1:0] rect_bytes;
    logic [PW-1:0] rect_pitch;
    logic          busy;
    logic          done;

    int total = 0;
    int bad   = 0;

    int mx [DEPTH];
    int my [DEPTH];
    int mw [DEPTH];
    int mh [DEPTH];
    int qh = 0;
    int qt = 0;
    bit minv = 1'b0;

    always #2 clk = ~clk;

    redraw_queue i_redraw_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
        .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h),
        .refresh(refresh), .invalidate(invalidate),
        .scr_w(scr_w), .scr_h(scr_h), .bpp(bpp),
        .rect_valid(rect_valid), .rect_ready(rect_ready),
        .rect_addr(rect_addr), .rect_rows(rect_rows),
        .rect_bytes(rect_bytes), .rect_pitch(rect_pitch),
        .busy(busy), .done(done)
    );

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected request for a stored region under the present screen settings.
    task automatic expect_of(int idx, output longint ea, output longint er,
                             output longint eb, output longint ep);
        longint x = mx[idx], y = my[idx], w = mw[idx], h = mh[idx];
        longint sw = scr_w, sh = scr_h, b = bpp;
        if (x + w > sw) begin
            if (x > sw) x = sw;
            w = sw - x;
        end
        if (y + h > sh) begin
            if (y > sh) y = sh;
            h = sh - y;
        end
        ea = b * x + b * sw * y;
        er = h;
        eb = b * w;
        ep = b * sw;
    endtask

    task automatic push_one(int x, int y, int w, int h);
        @(negedge clk);
        push_valid = 1'b1;
        push_x = CW'(x); push_y = CW'(y); push_w = CW'(w); push_h = CW'(h);
        mx[qt] = x; my[qt] = y; mw[qt] = w; mh[qt] = h;
        qt = (qt + 1) % DEPTH;
        @(posedge clk);
        #1 push_valid = 1'b0;
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        invalidate = 1'b1;
        minv = 1'b1;
        @(posedge clk);
        #1 invalidate = 1'b0;
    endtask

    // Refresh and consume the drain, comparing every accepted request.
    task automatic do_refresh(int exp_n, string tag, bit poke, bit lazy);
        int got = 0;
        int cyc = 0;
        bit seen = 1'b0;
        bit stall = 1'b0;
        longint sa = 0, sr = 0, sb = 0, sp = 0;
        longint ea, er, eb, ep;
        @(negedge clk);
        refresh = 1'b1;
        rect_ready = lazy ? ($urandom % 3 == 0) : ($urandom % 4 != 0);
        if (minv) begin
            qh = qt;
            minv = 1'b0;
        end
        forever begin
            if (stall) begin
                chk(rect_valid && rect_addr == sa && rect_rows == sr &&
                    rect_bytes == sb && rect_pitch == sp,
                    "R10", "held request addr", rect_addr, sa);
            end
            if (rect_valid && rect_ready) begin
                expect_of(qh, ea, er, eb, ep);
                qh = (qh + 1) % DEPTH;
                chk(rect_addr == ea, tag, "addr", rect_addr, ea);
                chk(rect_rows == er, tag, "rows", rect_rows, er);
                chk(rect_bytes == eb, tag, "bytes", rect_bytes, eb);
                chk(rect_pitch == ep, tag, "pitch", rect_pitch, ep);
                got++;
            end
            stall = rect_valid && !rect_ready;
            sa = rect_addr; sr = rect_rows; sb = rect_bytes; sp = rect_pitch;
            if (done) begin
                seen = 1'b1;
                break;
            end
            cyc++;
            if (cyc > 4000) break;
            @(negedge clk);
            refresh = poke && (cyc == 3);
            if (poke && cyc == 3) chk(busy, "R8", "busy at extra refresh", busy, 1);
            rect_ready = lazy ? ($urandom % 3 == 0) : ($urandom % 4 != 0);
        end
        refresh = 1'b0;
        chk(seen, "R9", "done raised", seen, 1);
        chk(!busy && !rect_valid, "R9", "idle with done", busy, 0);
        chk(got == exp_n, tag, "region count", got, exp_n);
        @(negedge clk);
        chk(!done && !busy && !rect_valid, "R9", "single done pulse", done, 0);
        repeat (3) @(negedge clk);
        chk(!rect_valid && !done, "R8", "no extra drain", rect_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!rect_valid && !busy && !done, "R1", "outputs in reset", rect_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rect_valid && !busy && !done, "R1", "outputs after reset", busy, 0);

        // R1: empty queue drains with no region.
        do_refresh(0, "R1", 1'b0, 1'b0);

        // R2 and R7: regions inside the screen, order kept.
        push_one(10, 20, 30, 40);
        push_one(0, 0, 640, 480);
        push_one(639, 479, 1, 1);
        do_refresh(3, "R7", 1'b0, 1'b0);

        // R5: horizontal clip, partly and fully off screen.
        push_one(600, 5, 100, 7);
        push_one(700, 5, 10, 7);
        do_refresh(2, "R5", 1'b0, 1'b0);

        // R6: vertical clip, partly and fully off screen.
        push_one(3, 470, 8, 50);
        push_one(3, 900, 8, 2);
        do_refresh(2, "R6", 1'b0, 1'b0);

        // R4: invalidated refresh drops, then the flag is gone.
        push_one(1, 1, 2, 2);
        push_one(5, 5, 2, 2);
        push_one(9, 9, 2, 2);
        pulse_inval();
        do_refresh(0, "R4", 1'b0, 1'b0);
        push_one(7, 8, 9, 10);
        do_refresh(1, "R4", 1'b0, 1'b0);

        // R3: depth+1 pushes leave only the last.
        for (int i = 0; i < DEPTH + 1; i++) begin
            push_one(i % 600, i % 400, 4, 4);
        end
        do_refresh(1, "R3", 1'b0, 1'b0);

        // R11: screen size and bpp changed after the pushes.
        push_one(300, 200, 100, 100);
        push_one(50, 60, 70, 80);
        @(negedge clk);
        scr_w = 12'd320; scr_h = 12'd240; bpp = 3'd2;
        do_refresh(2, "R11", 1'b0, 1'b0);

        // R8 and R10: extra refresh during a slow, stalled drain.
        for (int i = 0; i < 10; i++) begin
            push_one(i * 13, i * 7, 20 + i, 15 + i);
        end
        do_refresh(10, "R8", 1'b1, 1'b1);

        // R2: random bursts with random screen settings and back-pressure.
        for (int r = 0; r < 25; r++) begin
            int n = $urandom % 18;
            @(negedge clk);
            scr_w = CW'(1 + $urandom % 1024);
            scr_h = CW'(1 + $urandom % 768);
            bpp   = BW'(1 + $urandom % 4);
            for (int k = 0; k < n; k++) begin
                push_one($urandom % 1200, $urandom % 900,
                         $urandom % 700, $urandom % 500);
            end
            if (r % 6 == 5) begin
                pulse_inval();
                do_refresh(0, "R4", 1'b0, (r % 2) == 1);
            end else begin
                do_refresh(n, "R2", 1'b0, (r % 2) == 1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule